// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is the target side of a two-wire serial memory. It sits behind a pair of open-drain pads and holds 2048 bytes in an internal register array. A fast system clock oversamples the bus clock and data lines. A controller on the bus opens a transfer, names the device and a byte location, and then streams bytes in or out. The block acknowledges each byte that it accepts. It returns stored bytes in order for as long as the controller keeps acknowledging. It drops the data line only by asserting an output enable, so the pad itself pulls low.

A write transfer carries a device byte and a low address byte, followed by at most 32 data bytes. These stay inside one aligned 32-byte page. A read transfer can start at the current pointer. It can also start at any location, using a short write header followed by a repeated START. A write-protect input leaves the protocol unchanged but keeps the array from being modified.

Controller state machine states: ST_IDLE (bus released, waiting for START), ST_DEV (shifting in the device byte), ST_DEV_ACK (ninth clock of the device byte), ST_ADDR (shifting in the low address byte), ST_ADDR_ACK, ST_WDATA (shifting in a data byte), ST_WDATA_ACK, ST_RDATA (shifting a stored byte out), ST_RDATA_ACK (sampling the controller's acknowledge) and ST_WAIT (ignoring the bus until START or STOP). Transitions: a STOP from any state goes to ST_IDLE. A START from any state goes to ST_DEV. Each receive state moves to its acknowledge state on the SCL fall that ends its eighth bit. ST_DEV_ACK moves on the next SCL fall to ST_WAIT (no match), ST_RDATA (read) or ST_ADDR (write). ST_ADDR_ACK and ST_WDATA_ACK move to ST_WDATA. ST_RDATA moves to ST_RDATA_ACK after eight bits. ST_RDATA_ACK moves to ST_RDATA on an acknowledge and to ST_WAIT on a missing acknowledge.

Top module: `i2c_ee_target`

## Requirements
- R1: After reset, and whenever the controller is idle, `sda_oe` is 0 (data line released).
- R2: SDA rising while SCL is high is a STOP. It returns the block to idle. Bytes clocked after a STOP without a new START get no acknowledge.
- R3: A device byte whose upper four bits are 4'b1010 is acknowledged. Any other device byte is not, and the rest of that transfer is ignored until the next START or STOP.
- R4: An acknowledge holds SDA low for the whole high phase of the ninth clock. The block changes `sda_oe` only while SCL is low.
- R5: In a write, device byte bits [3:1] become address bits [10:8] and the second byte becomes bits [7:0]. Bit 0 of the device byte is 0 for a write. Data bits are taken MSB first, one per SCL high phase, and stored from that address on.
- R6: During a write the pointer advances only in its low five bits, so a write wraps inside its aligned 32-byte page.
- R7: The first 32 data bytes of a write are acknowledged. The 33rd and later data bytes are neither acknowledged nor stored.
- R8: While `wp_i` is 1, data bytes are still acknowledged but the array keeps its contents.
- R9: A device byte with bit 0 = 1 replaces address bits [10:8] and starts a read. Bytes leave MSB first from the pointer. The pointer advances after every byte over the whole array, wrapping 0x7FF to 0x000, for as long as the controller acknowledges.
- R10: A missing controller acknowledge ends a read, and SDA stays released until the next START or STOP.
- R11: A START in the middle of a byte drops that byte without storing it, and reception restarts with a device byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (wired level) |
| wp_i | input | 1 | Write protect, 1 blocks array updates |
| sda_oe | output | 1 | 1 pulls the data pad low, 0 releases it |

## Verification
The clocked properties assume that SDA changes only while SCL is low, except for START and STOP. They also assume that each SCL level lasts several system clocks, so that the synchronized copies of both lines keep their order. The stimulus meets both assumptions: every phase lasts at least ten system clocks, data moves only in the middle of the low phase, and START and STOP are issued only with SCL held high on both sides of the data edge. The bench models the wired-AND bus, so the block sees its own acknowledge and read bits on `sda_i`, as a real pad would give them.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_WAIT
    } ee_state_e;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] raw_lines;
    logic [1:0] synced;
    logic [1:0] prev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw_lines[g]};
            end
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= synced;
        end
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
    import i2c_ee_pkg::*;
#(
    parameter int unsigned MEM_DEPTH  = 2048,
    parameter int unsigned PAGE_BYTES = 32,
    localparam int unsigned AW        = $clog2(MEM_DEPTH),
    localparam int unsigned PL        = $clog2(PAGE_BYTES),
    localparam int unsigned HI_W      = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          wp_i,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata
);

    localparam logic [PL:0] PAGE_LIM = (PL+1)'(PAGE_BYTES);

    ee_state_e     state, state_d;
    logic [3:0]    bit_cnt, bit_cnt_d;
    logic [7:0]    shreg, shreg_d;
    logic [AW-1:0] ptr, ptr_d;
    logic [PL:0]   wr_cnt, wr_cnt_d;
    logic          ack_q, ack_d;
    logic          rw_q, rw_d;
    logic          we_d;
    logic          byte_done;
    logic          dev_ok;

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign dev_ok    = (shreg[7:4] == DEV_CODE);

    // next-state logic
    always_comb begin
        state_d   = state;
        bit_cnt_d = bit_cnt;
        shreg_d   = shreg;
        ptr_d     = ptr;
        wr_cnt_d  = wr_cnt;
        ack_d     = ack_q;
        rw_d      = rw_q;
        we_d      = 1'b0;
        if (stop_det) begin
            state_d   = ST_IDLE;
            bit_cnt_d = '0;
            ack_d     = 1'b0;
        end else if (start_det) begin
            state_d   = ST_DEV;
            bit_cnt_d = '0;
            ack_d     = 1'b0;
            wr_cnt_d  = '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: begin
                end
                ST_DEV: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg_d   = {shreg[6:0], sda_s};
                        bit_cnt_d = bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt_d = '0;
                        ack_d     = dev_ok;
                        rw_d      = shreg[0];
                        if (dev_ok) begin
                            ptr_d[AW-1:8] = shreg[HI_W:1];
                        end
                        state_d = ST_DEV_ACK;
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        ack_d     = 1'b0;
                        bit_cnt_d = '0;
                        if (!ack_q) begin
                            state_d = ST_WAIT;
                        end else if (rw_q) begin
                            state_d = ST_RDATA;
                            shreg_d = rd_data;
                            ptr_d   = ptr + AW'(1);
                        end else begin
                            state_d = ST_ADDR;
                        end
                    end
                end
                ST_ADDR: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg_d   = {shreg[6:0], sda_s};
                        bit_cnt_d = bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt_d  = '0;
                        ack_d      = 1'b1;
                        ptr_d[7:0] = shreg;
                        state_d    = ST_ADDR_ACK;
                    end
                end
                ST_ADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        ack_d   = 1'b0;
                        state_d = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg_d   = {shreg[6:0], sda_s};
                        bit_cnt_d = bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt_d = '0;
                        state_d   = ST_WDATA_ACK;
                        if (wr_cnt < PAGE_LIM) begin
                            ack_d    = 1'b1;
                            wr_cnt_d = wr_cnt + 1'b1;
                            we_d     = !wp_i;
                            ptr_d    = {ptr[AW-1:PL], ptr[PL-1:0] + PL'(1)};
                        end else begin
                            ack_d = 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        bit_cnt_d = bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt_d = '0;
                            state_d   = ST_RDATA_ACK;
                        end else if (bit_cnt != 4'd0) begin
                            shreg_d = {shreg[6:0], 1'b0};
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        ack_d = !sda_s;
                    end else if (scl_fall) begin
                        ack_d = 1'b0;
                        if (ack_q) begin
                            state_d = ST_RDATA;
                            shreg_d = rd_data;
                            ptr_d   = ptr + AW'(1);
                        end else begin
                            state_d = ST_WAIT;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            wr_cnt  <= '0;
            ack_q   <= 1'b0;
            rw_q    <= 1'b0;
        end else begin
            state   <= state_d;
            bit_cnt <= bit_cnt_d;
            shreg   <= shreg_d;
            ptr     <= ptr_d;
            wr_cnt  <= wr_cnt_d;
            ack_q   <= ack_d;
            rw_q    <= rw_d;
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe = ack_q;
            ST_RDATA:                              sda_oe = ~shreg[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign mem_we    = we_d;
    assign mem_addr  = ptr;
    assign mem_wdata = shreg;

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    assert_stop_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    assert_oe_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && byte_done) |=> $stable(ptr[AW-1:PL]));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= PAGE_LIM);

    assert_nack_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA_ACK && scl_fall && !ack_q && !start_det && !stop_det)
        |=> (state == ST_WAIT && !sda_oe));

    assert_start_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_DEV && bit_cnt == 4'd0));

endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target #(
    parameter int unsigned MEM_DEPTH   = 2048,
    parameter int unsigned PAGE_BYTES  = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);

    localparam int unsigned AW = $clog2(MEM_DEPTH);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;

    i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ee_ctrl #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .wp_i      (wp_i),
        .rd_data   (mem_rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    i2c_ee_array #(.DEPTH(MEM_DEPTH), .WIDTH(8)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/i2c_ee_target_tb.sv
`timescale 1ns/1ps
module i2c_ee_target_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] wbuf [40];
    logic       wack [40];
    logic [7:0] rbuf [8];
    logic       hdr_ack [4];

    // address[18:8], data[7:0]
    localparam logic [18:0] VEC [10] = '{
        {11'h000, 8'h11}, {11'h7FF, 8'hEE}, {11'h7FE, 8'hD7}, {11'h123, 8'h5A},
        {11'h3C5, 8'hC3}, {11'h555, 8'hA5}, {11'h2AA, 8'h96}, {11'h120, 8'h3B},
        {11'h005, 8'h3C}, {11'h0FF, 8'h81}
    };

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_ee_target u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic seen);
        tick(5); sda_m = b;
        tick(5); scl = 1'b1;
        tick(5); seen = sda_line;
        tick(5); scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(5); sda_m = 1'b1;
        tick(5); scl = 1'b1;
        tick(10); sda_m = 1'b0;
        tick(10); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(5); sda_m = 1'b0;
        tick(5); scl = 1'b1;
        tick(10); sda_m = 1'b1;
        tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            b[i] = s;
        end
        bit_xfer(!m_ack, s);
    endtask

    task automatic do_write(input logic [10:0] addr, input int n);
        logic a;
        bus_start();
        send_byte({4'hA, addr[10:8], 1'b0}, a); hdr_ack[0] = a;
        send_byte(addr[7:0], a);                hdr_ack[1] = a;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            wack[k] = a;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [10:0] addr, input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte({4'hA, addr[10:8], 1'b0}, a); hdr_ack[0] = a;
        send_byte(addr[7:0], a);                hdr_ack[1] = a;
        bus_start();
        send_byte({4'hA, addr[10:8], 1'b1}, a); hdr_ack[2] = a;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            rbuf[k] = b;
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        tick(5);
        chk(sda_oe == 1'b0, "R1 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(10);
        chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

        // vector table: single-byte write then random read
        for (int v = 0; v < 10; v++) begin
            wbuf[0] = VEC[v][7:0];
            do_write(VEC[v][18:8], 1);
            chk(hdr_ack[0] && hdr_ack[1], "R3 R5 header ack on write", {hdr_ack[0], hdr_ack[1]}, 3);
            chk(wack[0] == 1'b1, "R4 R5 data ack", wack[0], 1);
            do_read(VEC[v][18:8], 1);
            chk(hdr_ack[2] == 1'b1, "R9 read device ack", hdr_ack[2], 1);
            chk(rbuf[0] == VEC[v][7:0], "R5 R9 readback", rbuf[0], VEC[v][7:0]);
        end

        // R6: page wrap during write
        wbuf[0] = 8'h61; wbuf[1] = 8'h62; wbuf[2] = 8'h63; wbuf[3] = 8'h64;
        do_write(11'h01E, 4);
        do_read(11'h01E, 2);
        chk(rbuf[0] == 8'h61 && rbuf[1] == 8'h62, "R6 page tail", {rbuf[0], rbuf[1]}, 16'h6162);
        do_read(11'h000, 2);
        chk(rbuf[0] == 8'h63 && rbuf[1] == 8'h64, "R6 wrapped to page start", {rbuf[0], rbuf[1]}, 16'h6364);

        // R7: 32-byte cap
        for (int k = 0; k < 32; k++) wbuf[k] = 8'h40 + 8'(k);
        wbuf[32] = 8'hEE; wbuf[33] = 8'hEF;
        do_write(11'h100, 34);
        chk(wack[31] == 1'b1, "R7 byte 32 acked", wack[31], 1);
        chk(wack[32] == 1'b0 && wack[33] == 1'b0, "R7 bytes 33 and 34 not acked", {wack[32], wack[33]}, 0);
        do_read(11'h100, 1);
        chk(rbuf[0] == 8'h40, "R7 overflow discarded", rbuf[0], 8'h40);

        // R9: sequential read across a page and across the array end
        do_read(11'h11E, 3);
        chk(rbuf[0] == 8'h5E && rbuf[1] == 8'h5F && rbuf[2] == 8'h3B, "R9 read crosses page",
            {rbuf[0], rbuf[1], rbuf[2]}, 24'h5E5F3B);
        do_read(11'h7FE, 3);
        chk(rbuf[0] == 8'hD7 && rbuf[1] == 8'hEE && rbuf[2] == 8'h63, "R9 read wraps array",
            {rbuf[0], rbuf[1], rbuf[2]}, 24'hD7EE63);

        // R8: write protect
        wp = 1'b1;
        wbuf[0] = 8'h99;
        do_write(11'h100, 1);
        chk(wack[0] == 1'b1, "R8 protected byte acked", wack[0], 1);
        wp = 1'b0;
        do_read(11'h100, 1);
        chk(rbuf[0] == 8'h40, "R8 array unchanged", rbuf[0], 8'h40);

        // R11: START in the middle of a data byte
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h05, a);
        for (int i = 0; i < 4; i++) bit_xfer(1'b1, a);
        bus_start();
        send_byte(8'hA1, a);
        chk(a == 1'b1, "R11 device byte after abort acked", a, 1);
        recv_byte(1'b0, b);
        bus_stop();
        chk(b == 8'h3C, "R11 aborted byte not stored", b, 8'h3C);

        // R10: controller NACK releases the line
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'hFF, a);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, b);
        chk(b == 8'h81, "R10 last byte value", b, 8'h81);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R10 line released after NACK", b, 8'hFF);
        bus_stop();

        // R3: wrong device code
        bus_start();
        send_byte(8'hB0, a);
        chk(a == 1'b0, "R3 wrong code not acked", a, 0);
        send_byte(8'h00, a);
        chk(a == 1'b0, "R3 rest of transfer ignored", a, 0);
        bus_stop();

        // R2: after STOP, bytes without START are ignored
        chk(sda_oe == 1'b0, "R2 released after STOP", sda_oe, 0);
        tick(5); scl = 1'b0;
        send_byte(8'hA0, a);
        chk(a == 1'b0, "R2 byte without START ignored", a, 0);
        bus_stop();
        chk(sda_oe == 1'b0, "R1 idle released at end", sda_oe, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule